// File: doc/BRIEF.md
# Sparse Token-Chain Pixel Readout

This block drains a small pixel array once a detection window has closed. It visits only the pixels that recorded a hit. Each cell keeps a has-data flag, two time tags and a second-hit marker, all taken from the array's inputs when the window ends. The cells are linked in a token chain. The token passes through empty cells inside a single cycle. The first cell that holds data claims the token and places its packed word on a shared bus. A serializer then sends that word out one bit per fast clock.

The design uses one fast clock. An internal phase counter divides it by `RATIO` to form the cell-clock rhythm. A hit takes exactly one cell period, and its word leaves the block within that same period. A claimed cell clears its flag at the cell edge where it is read, so the token moves on by the next edge. The token can also come out of the chain's end while readout is running. When that happens the frame is over: a done flag stays high for one cell period and the block then returns to idle.

Top module: `tok_readout`

## Requirements
- R1: While reset is low and directly after it, `sdo`, `ser_first`, `ser_valid`, `busy` and `frame_done` are all 0.
- R2: A one-cycle `det_end` pulse in idle captures `pix_hit`, `pix_hit2`, `pix_ts1` and `pix_ts2` and raises `busy`. The first cell edge is the very next clock edge. Later changes to the pixel inputs do not affect that frame.
- R3: Pixel i sits at x = i mod NX and y = i / NX. Hit pixels are read in increasing i order, one word per RATIO clocks, with back-to-back words and no idle period for empty pixels.
- R4: The word is 32 bits, sent MSB first, one bit per clock. Bits 31:24 hold x, bits 23:16 hold y, bits 15:11 hold the first time tag, bits 10:6 hold the second time tag, bit 5 is the second-hit flag and bits 4:0 are 0. `ser_first` is high exactly while bit 31 is on `sdo`, and `ser_valid` is high while a word is being sent.
- R5: A pixel whose `pix_hit` bit is 0 produces no word, even if its second-hit flag or time tags are non-zero.
- R6: At the first cell edge where no cell holds data, `busy` falls and `frame_done` rises for exactly RATIO clocks. For n hit pixels, counting the first cell edge as edge 1, this edge is 1 + RATIO·n clocks in. `ser_valid` is 0 while `frame_done` is high.
- R7: A frame with no hit pixels raises `frame_done` at its first cell edge and sends no word.
- R8: `det_end` is ignored while `busy` or `frame_done` is high. The word sequence and the frame length stay unchanged, and no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast readout clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_end | input | 1 | End-of-detection pulse that launches the token |
| pix_hit | input | NX*NY | First-hit flag per pixel |
| pix_hit2 | input | NX*NY | Second-hit flag per pixel |
| pix_ts1 | input | NX*NY*TSW | First time tag per pixel, pixel i in slice i |
| pix_ts2 | input | NX*NY*TSW | Second time tag per pixel |
| sdo | output | 1 | Serial data, MSB first |
| ser_first | output | 1 | High while the word MSB is on sdo |
| ser_valid | output | 1 | High while a word is being sent |
| busy | output | 1 | Readout in progress |
| frame_done | output | 1 | End-of-frame flag, one cell period long |

## Verification
Two things happen at a cell edge. Claiming a new cell must coincide with the last bit of the previous word. Finding that the chain is empty must coincide with the last bit of the final word. Frames that put hits in the first and last pixels, in every pixel, and in no pixel test these edges. A scoreboard rebuilds each 32-bit word and checks that exactly RATIO bits separate consecutive `ser_first` marks. The frame length is measured against 1 + RATIO·n, so a missing or extra cell period in either case changes the count.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_RUN  = 2'd1,
      RD_DONE = 2'd2
   } rd_state_t;
endpackage

// File: rtl/rd_cell.sv
module rd_cell #(
   parameter int XW  = 8,
   parameter int YW  = 8,
   parameter int TSW = 5,
   parameter int CX  = 0,
   parameter int CY  = 0,
   localparam int PW = XW + YW + 2*TSW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cap,
   input  logic           adv,
   input  logic           hit_i,
   input  logic           hit2_i,
   input  logic [TSW-1:0] ts1_i,
   input  logic [TSW-1:0] ts2_i,
   input  logic           tok_i,
   output logic           tok_o,
   output logic           grant_o,
   output logic [PW-1:0]  word_o
);
   logic           has_q;
   logic           hit2_q;
   logic [TSW-1:0] ts1_q, ts2_q;

   // empty cell lets the token straight through
   assign tok_o   = tok_i & ~has_q;
   assign grant_o = tok_i & has_q;
   assign word_o  = {XW'(CX), YW'(CY), ts1_q, ts2_q, hit2_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         has_q  <= 1'b0;
         hit2_q <= 1'b0;
         ts1_q  <= '0;
         ts2_q  <= '0;
      end else if (cap) begin
         has_q  <= hit_i;
         hit2_q <= hit2_i;
         ts1_q  <= ts1_i;
         ts2_q  <= ts2_i;
      end else if (grant_o && adv) begin
         has_q  <= 1'b0;
      end
   end

   // R3: a cell read at a cell edge gives the token up afterwards
   a_r3_cell_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && adv && !cap) |=> !grant_o);
endmodule

// File: rtl/rd_bus.sv
module rd_bus #(
   parameter int N  = 16,
   parameter int PW = 27
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    grant,
   input  logic [N*PW-1:0] words,
   output logic [PW-1:0]   word
);
   always_comb begin
      word = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) word = word | words[i*PW +: PW];
      end
   end

   // R3: the chain never lets two cells drive the bus
   a_r3_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/rd_ser.sv
module rd_ser #(
   parameter int PW    = 27,
   parameter int RATIO = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          stop,
   input  logic [PW-1:0] din,
   output logic          sdo,
   output logic          first,
   output logic          valid
);
   logic [RATIO-1:0] sh_q;

   assign sdo = sh_q[RATIO-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         first <= 1'b0;
         valid <= 1'b0;
      end else if (load) begin
         sh_q  <= RATIO'(din) << (RATIO - PW);
         first <= 1'b1;
         valid <= 1'b1;
      end else if (stop) begin
         sh_q  <= '0;
         first <= 1'b0;
         valid <= 1'b0;
      end else begin
         sh_q  <= sh_q << 1;
         first <= 1'b0;
      end
   end

   // R4: the MSB marker lasts one bit slot
   a_r4_first_single: assert property (@(posedge clk) disable iff (!rst_n)
      first |=> !first);
   // R4: the marker only appears inside a valid word
   a_r4_first_valid: assert property (@(posedge clk) disable iff (!rst_n)
      first |-> valid);
endmodule

// File: rtl/tok_readout.sv
module tok_readout
   import rdo_pkg::*;
#(
   parameter int NX    = 4,
   parameter int NY    = 4,
   parameter int XW    = 8,
   parameter int YW    = 8,
   parameter int TSW   = 5,
   parameter int RATIO = 32,
   localparam int N    = NX * NY,
   localparam int PW   = XW + YW + 2*TSW + 1,
   localparam int PHW  = (RATIO > 1) ? $clog2(RATIO) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_end,
   input  logic [N-1:0]     pix_hit,
   input  logic [N-1:0]     pix_hit2,
   input  logic [N*TSW-1:0] pix_ts1,
   input  logic [N*TSW-1:0] pix_ts2,
   output logic             sdo,
   output logic             ser_first,
   output logic             ser_valid,
   output logic             busy,
   output logic             frame_done
);
   generate
      if (PW > RATIO) begin : g_bad_ratio
         $error("tok_readout: word of %0d bits does not fit %0d slots", PW, RATIO);
      end
      if (RATIO < 2) begin : g_bad_min
         $error("tok_readout: RATIO must be at least 2");
      end
      if (NX > (1 << XW) || NY > (1 << YW)) begin : g_bad_coord
         $error("tok_readout: coordinate fields too narrow for the array");
      end
   endgenerate

   rd_state_t       st_q;
   logic [PHW-1:0]  ph_q;
   logic            launch, cell_edge, last_tok;
   logic [N:0]      tok;
   logic [N-1:0]    grant;
   logic [N*PW-1:0] words;
   logic [PW-1:0]   bus_word;

   assign launch    = det_end && (st_q == RD_IDLE);
   assign cell_edge = (st_q != RD_IDLE) && (ph_q == '0);
   assign tok[0]    = (st_q == RD_RUN);
   assign last_tok  = tok[N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (launch || ph_q == PHW'(RATIO - 1)) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RD_IDLE;
      end else begin
         unique case (st_q)
            RD_IDLE: if (launch) st_q <= RD_RUN;
            RD_RUN:  if (cell_edge && last_tok) st_q <= RD_DONE;
            RD_DONE: if (cell_edge) st_q <= RD_IDLE;
            default: st_q <= RD_IDLE;
         endcase
      end
   end

   assign busy       = (st_q == RD_RUN);
   assign frame_done = (st_q == RD_DONE);

   for (genvar i = 0; i < N; i++) begin : g_cell
      rd_cell #(
         .XW(XW), .YW(YW), .TSW(TSW),
         .CX(i % NX), .CY(i / NX)
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .cap    (launch),
         .adv    (cell_edge),
         .hit_i  (pix_hit[i]),
         .hit2_i (pix_hit2[i]),
         .ts1_i  (pix_ts1[i*TSW +: TSW]),
         .ts2_i  (pix_ts2[i*TSW +: TSW]),
         .tok_i  (tok[i]),
         .tok_o  (tok[i+1]),
         .grant_o(grant[i]),
         .word_o (words[i*PW +: PW])
      );
   end

   rd_bus #(.N(N), .PW(PW)) u_bus (
      .clk  (clk),
      .rst_n(rst_n),
      .grant(grant),
      .words(words),
      .word (bus_word)
   );

   rd_ser #(.PW(PW), .RATIO(RATIO)) u_ser (
      .clk  (clk),
      .rst_n(rst_n),
      .load (busy && cell_edge && !last_tok),
      .stop (busy && cell_edge && last_tok),
      .din  (bus_word),
      .sdo  (sdo),
      .first(ser_first),
      .valid(ser_valid)
   );

   // R6: the done flag only follows a running readout
   a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_done) |-> $past(busy));
   // R6: serial output is quiet while the frame-end flag is up
   a_r6_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !ser_valid);
   // R8: a launch request mid-readout does not restart or stop it
   a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && det_end && !cell_edge) |=> busy);
   // R8: a launch request during the done period is dropped
   a_r8_ignore_done: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && det_end && !cell_edge) |=> frame_done);
endmodule

// File: tb/sim_tok_readout.sv
module sim_tok_readout;
   localparam int CLK_P = 10;
   localparam int NX = 4, NY = 4, TSW = 5, RATIO = 32;
   localparam int N = NX * NY;
   localparam int LIMIT = 100000;

   logic clk = 1'b0, rst_n = 1'b0, det_end = 1'b0;
   logic [N-1:0] pix_hit = '0, pix_hit2 = '0;
   logic [N*TSW-1:0] pix_ts1 = '0, pix_ts2 = '0;
   logic sdo, ser_first, ser_valid, busy, frame_done;

   int checks = 0, errors = 0, cycles = 0;
   logic [31:0] exp_q[$];
   logic [31:0] acc = '0;
   int nbits = 0;

   always #(CLK_P/2) clk = ~clk;

   tok_readout u0 (
      .clk(clk), .rst_n(rst_n), .det_end(det_end),
      .pix_hit(pix_hit), .pix_hit2(pix_hit2),
      .pix_ts1(pix_ts1), .pix_ts2(pix_ts2),
      .sdo(sdo), .ser_first(ser_first), .ser_valid(ser_valid),
      .busy(busy), .frame_done(frame_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_word(input int i, input logic h2,
                                           input logic [TSW-1:0] t1, input logic [TSW-1:0] t2);
      return {8'(i % NX), 8'(i / NX), t1, t2, h2, 5'b0};
   endfunction

   // monitor: rebuild serial words and compare against the scoreboard
   always @(negedge clk) begin
      if (rst_n && ser_valid) begin
         if (ser_first) begin
            if (nbits != 0 && nbits != RATIO) chk("R4 word spacing", nbits, RATIO);
            acc = {31'b0, sdo};
            nbits = 1;
         end else begin
            acc = {acc[30:0], sdo};
            nbits++;
         end
         if (nbits == RATIO) begin
            if (exp_q.size() == 0) chk("R5 unexpected word", acc, 32'hxxxx_xxxx);
            else chk("R4 word content", acc, exp_q.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == LIMIT) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // driver: push expected words, launch, measure the frame
   task automatic run_frame(input logic [N-1:0] h, input logic [N-1:0] h2,
                            input logic [N*TSW-1:0] t1, input logic [N*TSW-1:0] t2,
                            input bit poke_run, input bit poke_done, input string tag);
      int n = 0, cnt = 0, w = 0;
      @(negedge clk);
      pix_hit = h; pix_hit2 = h2; pix_ts1 = t1; pix_ts2 = t2;
      for (int i = 0; i < N; i++) begin
         if (h[i]) begin
            exp_q.push_back(mk_word(i, h2[i], t1[i*TSW +: TSW], t2[i*TSW +: TSW]));
            n++;
         end
      end
      det_end = 1'b1;
      @(negedge clk);
      det_end = 1'b0;
      // R2: inputs are held only at capture
      pix_hit = ~h; pix_hit2 = ~h2; pix_ts1 = ~t1; pix_ts2 = ~t2;
      chk({"R2 busy after launch ", tag}, busy, 1'b1);
      do begin
         @(negedge clk);
         cnt++;
         if (poke_run && cnt == 3) begin det_end = 1'b1; pix_hit = '1; end
         if (poke_run && cnt == 4) det_end = 1'b0;
      end while (!frame_done && cnt < 40 * RATIO);
      chk({"R6 frame length ", tag}, cnt, 1 + RATIO * n);
      w = 0;
      while (frame_done && w < 4 * RATIO) begin
         w++;
         if (busy) chk({"R6 busy low at done ", tag}, busy, 1'b0);
         if (poke_done && w == 3) det_end = 1'b1;
         if (poke_done && w == 4) det_end = 1'b0;
         @(negedge clk);
      end
      det_end = 1'b0;
      chk({"R6 done width ", tag}, w, RATIO);
      chk({"R3 all words seen ", tag}, exp_q.size(), 0);
      for (int k = 0; k < 40; k++) begin
         if (busy || ser_valid) chk({"R8 stays idle ", tag}, {busy, ser_valid}, 2'b00);
         @(negedge clk);
      end
      checks++;
   endtask

   initial begin
      logic [N*TSW-1:0] ta, tb;
      for (int i = 0; i < N; i++) begin
         ta[i*TSW +: TSW] = TSW'(3 * i + 1);
         tb[i*TSW +: TSW] = TSW'(31 - 2 * i);
      end
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {sdo, ser_first, ser_valid, busy, frame_done}, 5'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {sdo, ser_first, ser_valid, busy, frame_done}, 5'b0);

      run_frame(16'h0001, 16'h0001, ta, tb, 0, 0, "R3 single first pixel");
      run_frame(16'h8421, 16'h8001, ta, tb, 0, 0, "R3 R4 sparse diag");
      run_frame(16'h0000, 16'hffff, ta, tb, 0, 0, "R7 empty frame");
      run_frame(16'h0102, 16'hfefd, ta, tb, 0, 0, "R5 second flag without hit");
      run_frame(16'hffff, 16'haaaa, ta, tb, 0, 0, "R3 full array");
      run_frame(16'h8000, 16'h0000, ~ta, ~tb, 0, 0, "R3 last pixel only");
      run_frame(16'h0a50, 16'h0050, ta, tb, 1, 0, "R8 launch while busy");
      run_frame(16'h0003, 16'h0002, tb, ta, 0, 1, "R8 launch while done");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule